// File: doc/BRIEF.md
# Register Range Store Sequencer

This block copies a contiguous, wrap-around range of general registers into memory. A caller gives it a first register index, a last register index and a byte base address, then pulses a start strobe. The sequencer walks the register file one index at a time in ascending order. For each register it reads the register through a read port and issues one word write on a valid/ready memory write port. Each write goes to the word after the previous one.

When the last index is numerically below the first, the walk continues past the highest register and resumes at register 0. The number of words written is therefore the index distance modulo the register count, plus one. A single-cycle done pulse marks the end of the transfer. The incoming condition code passes straight through to the output, so the operation does not alter it.

A parameter selects whether the register file answers a read in the same cycle or one cycle later. In the second case the sequencer inserts one read cycle ahead of every write. Address translation, access faults and alignment are left to the surrounding logic.

Top module: `regrange_store`

## Requirements
- R1: While reset is asserted and in the first cycle after its release, `busy_o`, `done_o` and `mem_wr_valid_o` are all 0.
- R2: The first write of a transfer reads register `first_idx_i` and targets `base_addr_i`, both as sampled in the cycle `start_i` was accepted.
- R3: Each following write reads the register whose index is one above the previous one, taken modulo 16. It targets the previous address plus 4, taken modulo 2^32.
- R4: When `last_idx_i` is below `first_idx_i`, register 15 is followed by register 0 and the walk stops at `last_idx_i`.
- R5: Exactly ((last - first) mod 16) + 1 writes are accepted per transfer, so equal indices store one register and adjacent-below indices store all 16.
- R6: While `mem_wr_valid_o` is 1 and `mem_wr_ready_i` is 0, the write address, data and register index hold their values and valid stays 1.
- R7: `done_o` is 1 for exactly one cycle, the cycle right after the last write is accepted. In that cycle `busy_o` and `mem_wr_valid_o` are 0.
- R8: A `start_i` pulse while `busy_o` is 1 has no effect. The running transfer keeps its indices and addresses, and no further writes follow its done pulse.
- R9: `cc_o` equals `cc_i` in every cycle, whether idle or busy.
- R10: `mem_wr_data_o` carries the read data of the register named on `rf_rd_idx_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe, taken only while idle |
| first_idx_i | input | 4 | First register index of the range |
| last_idx_i | input | 4 | Last register index of the range |
| base_addr_i | input | 32 | Byte address of the first word |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle end-of-transfer pulse |
| rf_rd_idx_o | output | 4 | Register file read index |
| rf_rd_data_i | input | 32 | Register file read data |
| mem_wr_valid_o | output | 1 | Memory write request valid |
| mem_wr_ready_i | input | 1 | Memory write request accepted |
| mem_wr_addr_o | output | 32 | Memory write byte address |
| mem_wr_data_o | output | 32 | Memory write data |
| cc_i | input | 2 | Condition code in |
| cc_o | output | 2 | Condition code out, unchanged |

## Verification
The bench sweeps all 256 first/last index pairs under three ready patterns, and some bases sit near the top of the address space. This covers the wrap past register 15 and the carry of the address through 2^32. Equal indices and adjacent-below indices are the boundary cases. A counter off by one there would store zero, two, fifteen or seventeen words instead of one or sixteen. Stalls check that a design which advanced on valid alone, rather than on the handshake, would skip words. A start pulse injected mid-transfer would, in a design that honoured it, restart the index or chain a second transfer after done.

// File: rtl/stm_pkg.sv
package stm_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FETCH = 2'd1,
      ST_WRITE = 2'd2
   } stm_state_e;

endpackage

// File: rtl/stm_span.sv
module stm_span #(
   parameter int IDX_W = 4
) (
   input  logic [IDX_W-1:0] first_i,
   input  logic [IDX_W-1:0] last_i,
   output logic [IDX_W-1:0] offs_o
);

   // Modulo subtraction: the index width equals log2 of the register count,
   // so the natural wrap of the difference gives the circular distance.
   always_comb begin
      offs_o = last_i - first_i;
   end

endmodule

// File: rtl/stm_walk.sv
module stm_walk #(
   parameter int IDX_W  = 4,
   parameter int ADDR_W = 32,
   parameter int STEP   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic              adv_i,
   input  logic [IDX_W-1:0]  first_i,
   input  logic [ADDR_W-1:0] base_i,
   output logic [IDX_W-1:0]  idx_o,
   output logic [ADDR_W-1:0] addr_o
);

   localparam logic [ADDR_W-1:0] ADDR_INC = ADDR_W'(STEP);
   localparam logic [IDX_W-1:0]  IDX_INC  = IDX_W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_o  <= '0;
         addr_o <= '0;
      end else if (load_i) begin
         idx_o  <= first_i;
         addr_o <= base_i;
      end else if (adv_i) begin
         idx_o  <= idx_o + IDX_INC;
         addr_o <= addr_o + ADDR_INC;
      end
   end

   a_r3_no_load_and_adv : assert property (@(posedge clk) disable iff (!rst_n)
      !(load_i && adv_i));

endmodule

// File: rtl/stm_ctrl.sv
module stm_ctrl
   import stm_pkg::*;
#(
   parameter int IDX_W    = 4,
   parameter int READ_LAT = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [IDX_W-1:0] offs_i,
   input  logic             wr_ready_i,
   output logic             load_o,
   output logic             adv_o,
   output logic             wr_valid_o,
   output logic             busy_o,
   output logic             done_o
);

   stm_state_e       state_q, state_d;
   stm_state_e       issue_state;
   logic [IDX_W-1:0] left_q, left_d;
   logic             done_d;
   logic             last_beat;

   // Variant choice: with a registered register-file read a fetch cycle
   // precedes every write; otherwise writes are issued back to back.
   generate
      if (READ_LAT == 0) begin : g_direct
         assign issue_state = ST_WRITE;
      end else begin : g_staged
         assign issue_state = ST_FETCH;
      end
   endgenerate

   assign last_beat = (left_q == '0);

   always_comb begin
      state_d    = state_q;
      left_d     = left_q;
      done_d     = 1'b0;
      load_o     = 1'b0;
      adv_o      = 1'b0;
      wr_valid_o = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (start_i) begin
               load_o  = 1'b1;
               left_d  = offs_i;
               state_d = issue_state;
            end
         end
         ST_FETCH: begin
            state_d = ST_WRITE;
         end
         ST_WRITE: begin
            wr_valid_o = 1'b1;
            if (wr_ready_i) begin
               if (last_beat) begin
                  done_d  = 1'b1;
                  state_d = ST_IDLE;
               end else begin
                  adv_o   = 1'b1;
                  left_d  = left_q - IDX_W'(1);
                  state_d = issue_state;
               end
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         left_q  <= '0;
         done_o  <= 1'b0;
      end else begin
         state_q <= state_d;
         left_q  <= left_d;
         done_o  <= done_d;
      end
   end

   assign busy_o = (state_q != ST_IDLE);

   a_r7_done_single : assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   a_r7_done_after_accept : assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(wr_valid_o && wr_ready_i));

   a_r8_start_ignored : assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i && !(wr_valid_o && wr_ready_i)) |=> $stable(left_q));

endmodule

// File: rtl/regrange_store.sv
module regrange_store #(
   parameter int NUM_REGS = 16,
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 32,
   parameter int READ_LAT = 0,
   parameter int CC_W     = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       start_i,
   input  logic [$clog2(NUM_REGS)-1:0] first_idx_i,
   input  logic [$clog2(NUM_REGS)-1:0] last_idx_i,
   input  logic [ADDR_W-1:0]          base_addr_i,
   output logic                       busy_o,
   output logic                       done_o,
   output logic [$clog2(NUM_REGS)-1:0] rf_rd_idx_o,
   input  logic [DATA_W-1:0]          rf_rd_data_i,
   output logic                       mem_wr_valid_o,
   input  logic                       mem_wr_ready_i,
   output logic [ADDR_W-1:0]          mem_wr_addr_o,
   output logic [DATA_W-1:0]          mem_wr_data_o,
   input  logic [CC_W-1:0]            cc_i,
   output logic [CC_W-1:0]            cc_o
);

   localparam int IDX_W = $clog2(NUM_REGS);
   localparam int STEP  = DATA_W / 8;

   generate
      if (NUM_REGS < 2 || (NUM_REGS & (NUM_REGS - 1)) != 0) begin : g_bad_regs
         $error("NUM_REGS must be a power of two of at least 2");
      end
      if (DATA_W < 8 || (DATA_W % 8) != 0) begin : g_bad_data
         $error("DATA_W must be a whole number of bytes");
      end
      if (READ_LAT < 0 || READ_LAT > 1) begin : g_bad_lat
         $error("READ_LAT must be 0 or 1");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("ADDR_W too small");
      end
   endgenerate

   logic [IDX_W-1:0] offs;
   logic             load;
   logic             adv;

   stm_span #(
      .IDX_W (IDX_W)
   ) u_span (
      .first_i (first_idx_i),
      .last_i  (last_idx_i),
      .offs_o  (offs)
   );

   stm_ctrl #(
      .IDX_W    (IDX_W),
      .READ_LAT (READ_LAT)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .offs_i     (offs),
      .wr_ready_i (mem_wr_ready_i),
      .load_o     (load),
      .adv_o      (adv),
      .wr_valid_o (mem_wr_valid_o),
      .busy_o     (busy_o),
      .done_o     (done_o)
   );

   stm_walk #(
      .IDX_W  (IDX_W),
      .ADDR_W (ADDR_W),
      .STEP   (STEP)
   ) u_walk (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (load),
      .adv_i   (adv),
      .first_i (first_idx_i),
      .base_i  (base_addr_i),
      .idx_o   (rf_rd_idx_o),
      .addr_o  (mem_wr_addr_o)
   );

   assign mem_wr_data_o = rf_rd_data_i;
   assign cc_o          = cc_i;

   a_r2_first_beat : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> (mem_wr_addr_o == $past(base_addr_i)
                         && rf_rd_idx_o == $past(first_idx_i)));

   a_r3_step : assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr_valid_o && mem_wr_ready_i && busy_o) |=>
         (!busy_o || (mem_wr_addr_o == $past(mem_wr_addr_o) + ADDR_W'(STEP)
                      && rf_rd_idx_o == $past(rf_rd_idx_o) + IDX_W'(1))));

   a_r6_hold : assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr_valid_o && !mem_wr_ready_i) |=>
         (mem_wr_valid_o && $stable(mem_wr_addr_o) && $stable(rf_rd_idx_o)));

   a_r7_idle_on_done : assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!busy_o && !mem_wr_valid_o));

endmodule

// File: tb/regrange_store_bench.sv
module regrange_store_bench;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [3:0]  first_idx_i = '0;
   logic [3:0]  last_idx_i = '0;
   logic [31:0] base_addr_i = '0;
   logic        busy_o, done_o;
   logic [3:0]  rf_rd_idx_o;
   logic [31:0] rf_rd_data_i;
   logic        mem_wr_valid_o;
   logic        mem_wr_ready_i = 1'b0;
   logic [31:0] mem_wr_addr_o, mem_wr_data_o;
   logic [1:0]  cc_i = 2'd0;
   logic [1:0]  cc_o;

   int n_checks = 0;
   int n_fail   = 0;
   int cyc      = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic [31:0] rf_val(input logic [3:0] i);
      return 32'hC300_0000 ^ ({28'd0, i} * 32'h0011_0F0B) ^ {16'd0, 12'd0, ~i};
   endfunction

   assign rf_rd_data_i = rf_val(rf_rd_idx_o);

   regrange_store u_regrange_store (
      .clk            (clk),
      .rst_n          (rst_n),
      .start_i        (start_i),
      .first_idx_i    (first_idx_i),
      .last_idx_i     (last_idx_i),
      .base_addr_i    (base_addr_i),
      .busy_o         (busy_o),
      .done_o         (done_o),
      .rf_rd_idx_o    (rf_rd_idx_o),
      .rf_rd_data_i   (rf_rd_data_i),
      .mem_wr_valid_o (mem_wr_valid_o),
      .mem_wr_ready_i (mem_wr_ready_i),
      .mem_wr_addr_o  (mem_wr_addr_o),
      .mem_wr_data_o  (mem_wr_data_o),
      .cc_i           (cc_i),
      .cc_o           (cc_o)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   function automatic bit ready_pat(input int mode, input int c);
      case (mode)
         0: return 1'b1;
         1: return c[0];
         default: return ((c * 5) % 7) > 2;
      endcase
   endfunction

   task automatic run(input logic [3:0] f, input logic [3:0] l,
                      input logic [31:0] base, input int mode);
      int  n = int'(4'(l - f)) + 1;
      int  k = 0;
      int  guard = 0;
      bit  injected = 1'b0;
      logic [3:0]  eidx;
      logic [31:0] eaddr;
      @(negedge clk);
      first_idx_i = f; last_idx_i = l; base_addr_i = base; start_i = 1'b1;
      cc_i = f[1:0] ^ l[1:0];
      @(negedge clk);
      start_i = 1'b0;
      // R9: pass-through while busy
      chk(cc_o == cc_i, "R9 cc busy", {62'd0, cc_o}, {62'd0, cc_i});
      while (k < n && guard < 200) begin
         guard++;
         eidx  = f + 4'(k);
         eaddr = base + 32'(4 * k);
         // R2/R3/R4/R10: index, address and data of beat k; R6 covers stalled beats
         chk(mem_wr_valid_o && busy_o && !done_o, "R6 valid held while busy",
             {62'd0, mem_wr_valid_o, busy_o}, 64'd3);
         chk(rf_rd_idx_o == eidx, (k == 0) ? "R2 first index" :
             (eidx < f) ? "R4 wrapped index" : "R3 next index",
             {60'd0, rf_rd_idx_o}, {60'd0, eidx});
         chk(mem_wr_addr_o == eaddr, (k == 0) ? "R2 base address" : "R3 address step",
             {32'd0, mem_wr_addr_o}, {32'd0, eaddr});
         chk(mem_wr_data_o == rf_val(eidx), "R10 write data",
             {32'd0, mem_wr_data_o}, {32'd0, rf_val(eidx)});
         mem_wr_ready_i = ready_pat(mode, cyc);
         if (mode == 2 && k == 1 && !injected) begin
            // R8: start during a transfer must be ignored
            injected = 1'b1;
            start_i = 1'b1;
            first_idx_i = ~f; last_idx_i = ~l; base_addr_i = ~base;
         end
         @(negedge clk);
         start_i = 1'b0;
         if (mem_wr_ready_i) k++;
      end
      mem_wr_ready_i = 1'b0;
      // R5: exactly n beats were taken before done
      chk(k == n && guard < 200, "R5 beat count", 64'(k), 64'(n));
      // R7: done pulse, idle, no request
      chk(done_o && !busy_o && !mem_wr_valid_o, "R7 done pulse",
          {61'd0, done_o, busy_o, mem_wr_valid_o}, 64'd4);
      @(negedge clk);
      // R7 single cycle, R5/R8 no extra beat or chained transfer
      chk(!done_o && !busy_o && !mem_wr_valid_o,
          injected ? "R8 no chained transfer" : "R7 done single cycle",
          {61'd0, done_o, busy_o, mem_wr_valid_o}, 64'd0);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: held in reset
      chk(!busy_o && !done_o && !mem_wr_valid_o, "R1 reset state",
          {61'd0, busy_o, done_o, mem_wr_valid_o}, 64'd0);
      cc_i = 2'd3;
      #1;
      chk(cc_o == 2'd3, "R9 cc in reset", {62'd0, cc_o}, 64'd3);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy_o && !done_o && !mem_wr_valid_o, "R1 after release",
          {61'd0, busy_o, done_o, mem_wr_valid_o}, 64'd0);
      for (int f = 0; f < 16; f++) begin
         for (int l = 0; l < 16; l++) begin
            logic [31:0] b;
            b = ((f + l) % 4 == 3) ? (32'hFFFF_FFC0 + 32'(4 * f))
                                   : {12'h5A0, 4'(f), 4'(l), 12'h000};
            run(4'(f), 4'(l), b, (f * 16 + l) % 3);
         end
      end
      // R9: idle pass-through across all codes
      for (int c = 0; c < 4; c++) begin
         cc_i = 2'(c);
         #1;
         chk(cc_o == 2'(c), "R9 cc idle", {62'd0, cc_o}, 64'(c));
      end
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule